// File: doc/BRIEF.md
# Four-Stage Pipelined Parallel-Prefix Adder

This block adds two 16-bit operands and a carry-in with a Kogge-Stone prefix tree that is cut into four register stages. A new operand pair may be offered on every clock cycle. Each result leaves the block exactly four cycles after its operands were sampled, together with a valid flag that has travelled through the pipeline beside the data.

The first stage forms per-bit generate and propagate terms. The carry-in is treated as the generate term of an extra position below bit zero, so the tree handles it like any other carry. The second stage evaluates the prefix levels of span 1 and 2. The third stage evaluates spans 4 and 8 and forms the carry-out. The fourth stage combines each bit propagate with its prefix carry to give the sum. Every node of the tree is a two-input generate/propagate merge. The bit propagate terms ride along the pipeline registers so that the last stage can use them.

Top module: `ks_pipe_adder`

## Requirements
- R1: When `out_valid` is high, `{out_cout, out_sum}` equals the 17-bit value `in_a + in_b + in_cin` of the operands that caused it. `out_cout` is bit 16 and `out_sum` is bits 15..0.
- R2: Latency is exactly four cycles. Operands sampled at rising edge k appear on the outputs after rising edge k+3 and hold there until edge k+4.
- R3: Throughput is one addition per cycle. Operand pairs offered on consecutive cycles yield results on consecutive cycles, in issue order.
- R4: `out_valid` equals `in_valid` from four edges earlier. A cycle with `in_valid` low produces a cycle with `out_valid` low, and operands offered in that cycle have no effect on any result.
- R5: While `rst` is high, `out_valid` is low at every edge. Work in flight at reset is discarded. After reset is released, `out_valid` stays low until the first operands sampled after release reach the output, even if `in_valid` was high during reset.
- R6: A carry-in of 1 propagates across all 16 bits: `16'hFFFF + 16'h0000 + 1` gives sum 0 with carry-out 1.
- R7: All-ones plus one with carry-in 0 gives sum 0 with carry-out 1.
- R8: Zero plus zero with carry-in 0 gives sum 0 with carry-out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operands on this cycle are to be added |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_cin | input | 1 | Carry-in |
| out_valid | output | 1 | Result on this cycle belongs to an accepted operand pair |
| out_sum | output | 16 | Sum bits |
| out_cout | output | 1 | Carry-out |

## Verification
A wrong node in the prefix tree or a mis-aligned propagate register shows up as a wrong sum or carry-out bit on the very result that exercised it, four cycles after issue. Long carry chains such as all-ones plus one are driven to reach the deepest nodes. A fault in the valid pipeline shows as `out_valid` high or low one cycle off from the issue pattern. The scoreboard sees this on the first bubble or the first back-to-back pair after the fault. A reset fault shows as a stray valid within four cycles of releasing reset.

// File: rtl/ks_pkg.sv
package ks_pkg;

    localparam int unsigned ADD_W = 16;

    // group generate / propagate pair
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // two-input prefix operator: hi group spans above lo group
    function automatic gp_t gp_merge(gp_t hi, gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/ks_bit_gen.sv
module ks_bit_gen
    import ks_pkg::*;
#(
    parameter int unsigned W = ADD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output gp_t  [W:0]   gp_o
);
    // position 0 carries the carry-in as a pure generate term
    always_comb begin
        gp_o[0].g = cin_i;
        gp_o[0].p = 1'b0;
    end

    for (genvar i = 0; i < int'(W); i++) begin : g_bit
        always_comb begin
            gp_o[i+1].g = a_i[i] & b_i[i];
            gp_o[i+1].p = a_i[i] ^ b_i[i];
        end
    end
endmodule

// File: rtl/ks_prefix_levels.sv
module ks_prefix_levels
    import ks_pkg::*;
#(
    parameter int unsigned W     = ADD_W,
    parameter int unsigned FIRST = 0,
    parameter int unsigned COUNT = 2
) (
    input  gp_t [W:0] gp_i,
    output gp_t [W:0] gp_o
);
    gp_t [W:0] lvl [COUNT+1];

    assign lvl[0] = gp_i;

    for (genvar l = 0; l < int'(COUNT); l++) begin : g_lvl
        localparam int unsigned SPAN = 1 << (FIRST + l);
        for (genvar k = 0; k <= int'(W); k++) begin : g_node
            if (k >= int'(SPAN)) begin : g_merge
                assign lvl[l+1][k] = gp_merge(lvl[l][k], lvl[l][k-SPAN]);
            end else begin : g_pass
                assign lvl[l+1][k] = lvl[l][k];
            end
        end
    end

    assign gp_o = lvl[COUNT];
endmodule

// File: rtl/ks_sum_gen.sv
module ks_sum_gen #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] sum_o
);
    assign sum_o = prop_i ^ carry_i;
endmodule

// File: rtl/ks_pipe_adder.sv
module ks_pipe_adder
    import ks_pkg::*;
#(
    parameter int unsigned WIDTH = ADD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic             in_cin,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_sum,
    output logic             out_cout
);
    localparam int unsigned LEVELS  = $clog2(WIDTH);
    localparam int unsigned EARLY_L = LEVELS / 2;
    localparam int unsigned LATE_L  = LEVELS - EARLY_L;
    localparam int unsigned REACH   = 1 << LEVELS;
    localparam int unsigned STAGES  = 4;

    // ---------------- valid pipeline ----------------
    logic [STAGES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[STAGES-2:0], in_valid};
    end

    // ---------------- stage 1: bit terms ----------------
    gp_t [WIDTH:0] s1_d, s1_q;

    ks_bit_gen #(.W(WIDTH)) u_bits (
        .a_i   (in_a),
        .b_i   (in_b),
        .cin_i (in_cin),
        .gp_o  (s1_d)
    );

    always_ff @(posedge clk) s1_q <= s1_d;

    logic [WIDTH-1:0] s1_prop;
    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_p1
        assign s1_prop[i] = s1_q[i+1].p;
    end

    // ---------------- stage 2: early prefix levels ----------------
    gp_t [WIDTH:0]    s2_d, s2_q;
    logic [WIDTH-1:0] s2_prop;

    ks_prefix_levels #(.W(WIDTH), .FIRST(0), .COUNT(EARLY_L)) u_early (
        .gp_i (s1_q),
        .gp_o (s2_d)
    );

    always_ff @(posedge clk) begin
        s2_q    <= s2_d;
        s2_prop <= s1_prop;
    end

    // ---------------- stage 3: late prefix levels, carry-out ----------------
    gp_t [WIDTH:0]    s3_d;
    logic [WIDTH-1:0] s3_carry_d, s3_carry_q, s3_prop;
    logic             s3_cout_d, s3_cout_q;

    ks_prefix_levels #(.W(WIDTH), .FIRST(EARLY_L), .COUNT(LATE_L)) u_late (
        .gp_i (s2_q),
        .gp_o (s3_d)
    );

    // prefix at position i covers carry-in and bits below i
    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_c3
        assign s3_carry_d[i] = s3_d[i].g;
    end

    if (REACH > WIDTH) begin : g_cout_full
        assign s3_cout_d = s3_d[WIDTH].g;
    end else begin : g_cout_join
        gp_t top_grp;
        assign top_grp   = gp_merge(s3_d[WIDTH], s3_d[WIDTH-REACH]);
        assign s3_cout_d = top_grp.g;
    end

    always_ff @(posedge clk) begin
        s3_carry_q <= s3_carry_d;
        s3_prop    <= s2_prop;
        s3_cout_q  <= s3_cout_d;
    end

    // ---------------- stage 4: sum ----------------
    logic [WIDTH-1:0] s4_sum_d;

    ks_sum_gen #(.W(WIDTH)) u_sum (
        .prop_i  (s3_prop),
        .carry_i (s3_carry_q),
        .sum_o   (s4_sum_d)
    );

    always_ff @(posedge clk) begin
        out_sum  <= s4_sum_d;
        out_cout <= s3_cout_q;
    end

    assign out_valid = vld_q[STAGES-1];
endmodule

// File: rtl/ks_adder_checker.sv
module ks_adder_checker #(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             in_cin,
    input logic             out_valid,
    input logic [WIDTH-1:0] out_sum,
    input logic             out_cout
);
    // edges since reset release, saturating
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    logic [WIDTH:0] in_total;
    assign in_total = {1'b0, in_a} + {1'b0, in_b} + {{WIDTH{1'b0}}, in_cin};

    // R1 and R2: result equals operands sampled four edges earlier
    a_r1_sum_matches: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && out_valid) |-> ({out_cout, out_sum} == $past(in_total, 4)));

    // R4: valid flag delayed by four edges
    a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R5: no valid leaks out before the first post-reset operands arrive
    a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 3'd4) |-> !out_valid);

    // R5: valid pipeline cleared by reset
    a_r5_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

    // R3: back-to-back issue gives back-to-back results
    a_r3_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5 && out_valid && $past(out_valid)) |-> ($past(in_valid, 5) && $past(in_valid, 4)));
endmodule

bind ks_pipe_adder ks_adder_checker #(.WIDTH(WIDTH)) u_ks_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_cin    (in_cin),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .out_cout  (out_cout)
);

// File: tb/tb_ks_pipe_adder.sv
module tb_ks_pipe_adder;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         in_cin = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_sum;
    logic         out_cout;

    ks_pipe_adder #(.WIDTH(W)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_cin    (in_cin),
        .out_valid (out_valid),
        .out_sum   (out_sum),
        .out_cout  (out_cout)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [W:0] total;
        int         cyc;
        string      tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic c, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        in_cin = c;
        it.total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        it.cyc = cyc;
        it.tag = tag;
        q.push_back(it);
    endtask

    // idle cycle with junk operands that must not matter (R4)
    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0;
        in_a = W'($urandom);
        in_b = W'($urandom);
        in_cin = 1'($urandom);
    endtask

    // monitor: sample a quarter period after each rising edge
    initial begin
        forever begin
            bit    exp_v;
            item_t it;
            @(posedge clk);
            #5;
            n_cmp++;
            if (rst) begin
                if (out_valid !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R5: out_valid during reset got %b exp 0", out_valid);
                end
            end else begin
                exp_v = (q.size() > 0) && (q[0].cyc + 4 == cyc);
                if (out_valid !== exp_v) begin
                    n_bad++;
                    $display("FAIL %s: out_valid at cycle %0d got %b exp %b",
                             exp_v ? "R2" : "R4", cyc, out_valid, exp_v);
                end
                if (exp_v) begin
                    it = q.pop_front();
                    n_cmp++;
                    if ({out_cout, out_sum} !== it.total) begin
                        n_bad++;
                        $display("FAIL %s: result got %h exp %h", it.tag,
                                 {out_cout, out_sum}, it.total);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // directed corners
        issue(16'h0000, 16'h0000, 1'b0, "R8");
        issue(16'hFFFF, 16'h0001, 1'b0, "R7");
        issue(16'hFFFF, 16'h0000, 1'b1, "R6");
        issue(16'h8000, 16'h8000, 1'b0, "R1");
        issue(16'hAAAA, 16'h5555, 1'b1, "R1");
        issue(16'h7FFF, 16'h0000, 1'b1, "R1");
        issue(16'hFFFF, 16'hFFFF, 1'b1, "R1");
        bubble();
        bubble();

        // back-to-back random stream (R3)
        for (int i = 0; i < 200; i++)
            issue(W'($urandom), W'($urandom), 1'($urandom), "R3");

        // sparse issue with bubbles (R4)
        for (int i = 0; i < 100; i++) begin
            if ($urandom_range(0, 2) == 0) bubble();
            else issue(W'($urandom), W'($urandom), 1'($urandom), "R4");
        end

        // reset with work in flight and in_valid held high (R5)
        issue(16'h1234, 16'h4321, 1'b0, "R1");
        issue(16'hFFFF, 16'h0001, 1'b0, "R7");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_a = 16'hDEAD;
        in_b = 16'hBEEF;
        q.delete();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        repeat (6) bubble();

        issue(16'hFFFF, 16'h0000, 1'b1, "R6");
        for (int i = 0; i < 50; i++)
            issue(W'($urandom), W'($urandom), 1'($urandom), "R1");
        bubble();

        // drain
        while (q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule